// File: doc/BRIEF.md
# Hybrid Encryption Sequencing Controller

This block is the control path of a hybrid public-key encryption engine. It owns no arithmetic and no cipher. It starts five external units one at a time, and each unit is seen only through an enable pulse, a done strobe and data buses. The five units are a random scalar source, a scalar point multiplier, a hash unit, a MAC unit and a block cipher. The controller keeps the intermediate keys and points between stages and sets the order of the stages. It also produces the fields of the outgoing message.

There is no separate key-derivation step. The x-coordinate of the shared point is taken unchanged as the MAC key, and its hash is the cipher key. A send operation creates a fresh private scalar and computes the sender's public point. It then forms the shared point with the peer's public point and derives both keys. It tags and then encrypts, and finally presents ciphertext, public point and tag together. A receive operation uses a supplied private scalar and derives the same keys. It recomputes the tag and allows decryption only if that tag equals the received tag exactly. A mismatch discards the message.

Top module: `ecies_sequencer`

## Requirements
- R1: A `start` is accepted only when `busy` is low. A `start` raised while busy, including in the error state, changes neither the running sequence nor its mode. The sequence begins with its first enable one cycle after the accepting edge.
- R2: Send mode (`mode_rx`=0) runs the units in this order: random source, point multiply of `base_point`, point multiply of `peer_pub`, hash, MAC, cipher. Every enable is a single-cycle pulse and at most one enable is high at a time. Each enable is raised in the cycle after the done of the previous stage.
- R3: A done counts only in a cycle after the enable of the stage being waited on. A done from any other unit, or a done in the enable cycle itself, is ignored. Result data is captured in the cycle where the done counts.
- R4: The scalar for both point multiplies is the private scalar. The shared key is the upper W bits (the x half) of the second product. `hash_in` and `mac_key` carry the shared key, and `ciph_key` carries the hash result.
- R5: In send mode, `cg_valid` is high for exactly one cycle, the cycle after the cipher done. During that cycle `text_out` holds the cipher result, `pub_out` the first point product and `tag_out` the MAC result.
- R6: Receive mode (`mode_rx`=1) never enables the random source. It uses `own_priv` as the scalar and runs point multiply of `peer_pub`, hash and MAC in that order. It then compares the MAC result with `rx_tag` as captured at the accepting edge.
- R7: On an exact tag match, the cipher is enabled with `ciph_decrypt`=1. In the cycle after its done, `pt_valid` rises with the result on `text_out`. `pt_valid` stays high until the next accepted `start`, which clears it.
- R8: On a tag mismatch, the cipher is never enabled. `reject` is high for one cycle, the cycle after the MAC done, with `pt_valid` low and the block idle.
- R9: If a done does not arrive within TIMEOUT cycles after the enable, the block enters an error state with `err` and `busy` high and no further enables. A done in the TIMEOUT-th cycle is still accepted. Only reset leaves the error state.
- R10: During reset all enables, `busy`, `err`, `cg_valid`, `reject` and `pt_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new operation |
| mode_rx | input | 1 | 0 = send, 1 = receive |
| own_priv | input | W | Private scalar used in receive mode |
| base_point | input | 2W | Agreed base point {x, y} |
| peer_pub | input | 2W | Other party's public point {x, y} |
| rx_tag | input | TW | Tag received with the message |
| rng_en | output | 1 | Start the random scalar source |
| rng_done | input | 1 | Random source finished |
| rng_data | input | W | Random scalar |
| pm_en | output | 1 | Start the point multiplier |
| pm_scalar | output | W | Scalar operand |
| pm_point | output | 2W | Point operand |
| pm_done | input | 1 | Point multiplier finished |
| pm_result | input | 2W | Product point {x, y} |
| hash_en | output | 1 | Start the hash unit |
| hash_in | output | W | Hash operand (shared key) |
| hash_done | input | 1 | Hash finished |
| hash_out | input | W | Hash result |
| mac_en | output | 1 | Start the MAC unit |
| mac_key | output | W | MAC key (shared key) |
| mac_done | input | 1 | MAC finished |
| mac_tag | input | TW | MAC result |
| ciph_en | output | 1 | Start the cipher |
| ciph_decrypt | output | 1 | 1 = decrypt, 0 = encrypt |
| ciph_key | output | W | Cipher key (hash of shared key) |
| ciph_done | input | 1 | Cipher finished |
| ciph_out | input | DW | Cipher result |
| busy | output | 1 | Operation running or error state |
| err | output | 1 | Stage timeout occurred |
| cg_valid | output | 1 | Outgoing fields valid (one cycle) |
| reject | output | 1 | Tag mismatch, message discarded (one cycle) |
| pt_valid | output | 1 | Decrypted text valid |
| text_out | output | DW | Ciphertext or plaintext |
| pub_out | output | 2W | Sender public point |
| tag_out | output | TW | Computed tag |

## Verification
A wrong state register shows at the enable pins in the very next cycle. The order of the enables would be wrong, two enables would be high at once, or an enable would come early or late. A wrong captured key or point shows on the operand buses in the cycle of the next enable that uses it, which is well before the message fields appear. A faulty tag compare or timeout counter shows as a `reject`, `pt_valid`, `ciph_en` or `err` value that is off by at least one cycle from the cycle the model predicts.

// File: rtl/ecies_sequencer.sv
module ecies_sequencer #(
  parameter int W       = 32,
  parameter int DW      = 32,
  parameter int TW      = 32,
  parameter int TIMEOUT = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            mode_rx,
  input  logic [W-1:0]    own_priv,
  input  logic [2*W-1:0]  base_point,
  input  logic [2*W-1:0]  peer_pub,
  input  logic [TW-1:0]   rx_tag,
  output logic            rng_en,
  input  logic            rng_done,
  input  logic [W-1:0]    rng_data,
  output logic            pm_en,
  output logic [W-1:0]    pm_scalar,
  output logic [2*W-1:0]  pm_point,
  input  logic            pm_done,
  input  logic [2*W-1:0]  pm_result,
  output logic            hash_en,
  output logic [W-1:0]    hash_in,
  input  logic            hash_done,
  input  logic [W-1:0]    hash_out,
  output logic            mac_en,
  output logic [W-1:0]    mac_key,
  input  logic            mac_done,
  input  logic [TW-1:0]   mac_tag,
  output logic            ciph_en,
  output logic            ciph_decrypt,
  output logic [W-1:0]    ciph_key,
  input  logic            ciph_done,
  input  logic [DW-1:0]   ciph_out,
  output logic            busy,
  output logic            err,
  output logic            cg_valid,
  output logic            reject,
  output logic            pt_valid,
  output logic [DW-1:0]   text_out,
  output logic [2*W-1:0]  pub_out,
  output logic [TW-1:0]   tag_out
);
  localparam int PW = 2 * W;
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST_WAIT = CW'(TIMEOUT - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RNG, ST_PUB, ST_SHR, ST_HASH, ST_MAC, ST_CIPH, ST_FAIL
  } state_t;

  state_t         state;
  logic           fire;
  logic [CW-1:0]  wcnt;
  logic           mode_q;
  logic [W-1:0]   priv_q;
  logic [PW-1:0]  pub_q;
  logic [W-1:0]   shared_q;
  logic [W-1:0]   key_q;
  logic [TW-1:0]  tag_q;
  logic [TW-1:0]  rxtag_q;
  logic [DW-1:0]  text_q;
  logic           cg_q, rej_q, ptv_q;
  logic           stage_done;
  logic           tag_ok;

  always_comb begin
    case (state)
      ST_RNG:          stage_done = rng_done;
      ST_PUB, ST_SHR:  stage_done = pm_done;
      ST_HASH:         stage_done = hash_done;
      ST_MAC:          stage_done = mac_done;
      ST_CIPH:         stage_done = ciph_done;
      default:         stage_done = 1'b0;
    endcase
  end

  assign tag_ok = (mac_tag == rxtag_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      fire     <= 1'b0;
      wcnt     <= '0;
      mode_q   <= 1'b0;
      priv_q   <= '0;
      pub_q    <= '0;
      shared_q <= '0;
      key_q    <= '0;
      tag_q    <= '0;
      rxtag_q  <= '0;
      text_q   <= '0;
      cg_q     <= 1'b0;
      rej_q    <= 1'b0;
      ptv_q    <= 1'b0;
    end else begin
      cg_q  <= 1'b0;
      rej_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            mode_q  <= mode_rx;
            rxtag_q <= rx_tag;
            ptv_q   <= 1'b0;
            fire    <= 1'b1;
            wcnt    <= '0;
            if (mode_rx) begin
              priv_q <= own_priv;
              state  <= ST_SHR;
            end else begin
              state  <= ST_RNG;
            end
          end
        end
        ST_FAIL: ;
        default: begin
          if (fire) begin
            fire <= 1'b0;
            wcnt <= '0;
          end else if (stage_done) begin
            fire <= 1'b1;
            case (state)
              ST_RNG: begin
                priv_q <= rng_data;
                state  <= ST_PUB;
              end
              ST_PUB: begin
                pub_q <= pm_result;
                state <= ST_SHR;
              end
              ST_SHR: begin
                shared_q <= pm_result[PW-1 -: W];
                state    <= ST_HASH;
              end
              ST_HASH: begin
                key_q <= hash_out;
                state <= ST_MAC;
              end
              ST_MAC: begin
                tag_q <= mac_tag;
                if (mode_q && !tag_ok) begin
                  state <= ST_IDLE;
                  fire  <= 1'b0;
                  rej_q <= 1'b1;
                  ptv_q <= 1'b0;
                end else begin
                  state <= ST_CIPH;
                end
              end
              default: begin
                text_q <= ciph_out;
                state  <= ST_IDLE;
                fire   <= 1'b0;
                if (mode_q) ptv_q <= 1'b1;
                else        cg_q  <= 1'b1;
              end
            endcase
          end else if (wcnt == LAST_WAIT) begin
            state <= ST_FAIL;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign rng_en       = fire && (state == ST_RNG);
  assign pm_en        = fire && (state == ST_PUB || state == ST_SHR);
  assign hash_en      = fire && (state == ST_HASH);
  assign mac_en       = fire && (state == ST_MAC);
  assign ciph_en      = fire && (state == ST_CIPH);

  assign pm_scalar    = priv_q;
  assign pm_point     = (state == ST_PUB) ? base_point : peer_pub;
  assign hash_in      = shared_q;
  assign mac_key      = shared_q;
  assign ciph_key     = key_q;
  assign ciph_decrypt = mode_q;

  assign busy     = (state != ST_IDLE);
  assign err      = (state == ST_FAIL);
  assign cg_valid = cg_q;
  assign reject   = rej_q;
  assign pt_valid = ptv_q;
  assign text_out = text_q;
  assign pub_out  = pub_q;
  assign tag_out  = tag_q;

  assert_one_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rng_en, pm_en, hash_en, mac_en, ciph_en}));

  assert_enable_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rng_en || pm_en || hash_en || mac_en || ciph_en) |=>
      !(rng_en || pm_en || hash_en || mac_en || ciph_en));

  assert_cg_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cg_valid |=> !cg_valid);

  assert_decrypt_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ciph_en && ciph_decrypt) |-> (tag_q == rxtag_q));

  assert_reject_discard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> (!pt_valid && !busy && !cg_valid));

  assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (err && busy && !(rng_en || pm_en || hash_en || mac_en || ciph_en)));

  assert_no_rng_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q) |-> !rng_en);
endmodule

// File: tb/ecies_sequencer_test.sv
module ecies_sequencer_test;
  localparam int W  = 32;
  localparam int TO = 8;
  localparam logic [W-1:0] SEED = 32'hC0FF_EE11;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  always #4 clk = ~clk;

  logic          start = 0, mode_rx = 0;
  logic [W-1:0]  own_priv = 32'h1357_9BDF;
  logic [63:0]   base_point = 64'h0123_4567_89AB_CDEF;
  logic [63:0]   peer_pub   = 64'hFEDC_BA98_7654_3210;
  logic [W-1:0]  rx_tag = '0;
  logic rng_en, pm_en, hash_en, mac_en, ciph_en, ciph_decrypt;
  logic [W-1:0]  rng_data, pm_scalar, hash_in, hash_out, mac_key, mac_tag, ciph_key, ciph_out;
  logic [63:0]   pm_point, pm_result, pub_out;
  logic [W-1:0]  text_out, tag_out;
  logic busy, err, cg_valid, reject, pt_valid;
  logic [4:0] en_v, done_v, inj = 0;
  logic echo = 0;
  int lat [5];
  int cnt [5];
  int total = 0, bad = 0;

  function automatic logic [63:0] pmf(logic [63:0] pt, logic [W-1:0] sc);
    return {pt[63:32] ^ sc ^ 32'h5A17_C3E9, pt[31:0] + sc};
  endfunction
  function automatic logic [W-1:0] hf(logic [W-1:0] k);
    return k * 32'h9E37_79B1 + 32'd7;
  endfunction
  function automatic logic [W-1:0] mf(logic [W-1:0] k);
    return {k[15:0], k[31:16]} ^ 32'hA5A5_5A5A;
  endfunction
  function automatic logic [W-1:0] cf(logic [W-1:0] k, logic d);
    return d ? (k ^ 32'h3C3C_00FF) : (k ^ 32'h0BAD_F00D);
  endfunction
  function automatic int unit_of(int s);
    case (s)
      0: return 0;
      1, 2: return 1;
      3: return 2;
      4: return 3;
      default: return 4;
    endcase
  endfunction

  ecies_sequencer #(.W(W), .DW(W), .TW(W), .TIMEOUT(TO)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_rx(mode_rx), .own_priv(own_priv),
    .base_point(base_point), .peer_pub(peer_pub), .rx_tag(rx_tag),
    .rng_en(rng_en), .rng_done(done_v[0]), .rng_data(rng_data),
    .pm_en(pm_en), .pm_scalar(pm_scalar), .pm_point(pm_point), .pm_done(done_v[1]), .pm_result(pm_result),
    .hash_en(hash_en), .hash_in(hash_in), .hash_done(done_v[2]), .hash_out(hash_out),
    .mac_en(mac_en), .mac_key(mac_key), .mac_done(done_v[3]), .mac_tag(mac_tag),
    .ciph_en(ciph_en), .ciph_decrypt(ciph_decrypt), .ciph_key(ciph_key), .ciph_done(done_v[4]), .ciph_out(ciph_out),
    .busy(busy), .err(err), .cg_valid(cg_valid), .reject(reject), .pt_valid(pt_valid),
    .text_out(text_out), .pub_out(pub_out), .tag_out(tag_out));

  assign en_v      = {ciph_en, mac_en, hash_en, pm_en, rng_en};
  assign rng_data  = SEED;
  assign pm_result = pmf(pm_point, pm_scalar);
  assign hash_out  = hf(hash_in);
  assign mac_tag   = mf(mac_key);
  assign ciph_out  = cf(ciph_key, ciph_decrypt);

  always @(posedge clk) begin
    for (int i = 0; i < 5; i++) begin
      if (!rst_n) cnt[i] <= 0;
      else if (en_v[i]) cnt[i] <= lat[i];
      else if (cnt[i] > 0) cnt[i] <= cnt[i] - 1;
    end
  end
  always_comb begin
    for (int i = 0; i < 5; i++) done_v[i] = (cnt[i] == 1) | inj[i] | (echo & en_v[i]);
  end

  task automatic chk(bit ok, string r, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at %0t: actual=%h expected=%h", r, $time, act, exp);
    end
  endtask

  // reference model
  int q[$];
  bit m_fire = 0, m_err = 0, m_cg = 0, m_rej = 0, m_ptv = 0, m_mode = 0;
  int m_wait = 0;
  logic [W-1:0] m_priv = 0, m_sh = 0, m_rxtag = 0;

  always @(negedge clk) begin
    logic [4:0] exp_en;
    string rt;
    if (!rst_n) begin
      q.delete(); m_fire = 0; m_wait = 0; m_err = 0; m_cg = 0; m_rej = 0; m_ptv = 0;
    end
    rt = !rst_n ? "R10" : "R2/R3";
    exp_en = '0;
    if (q.size() > 0 && m_fire && !m_err) exp_en[unit_of(q[0])] = 1'b1;
    chk(en_v === exp_en, rt, 64'(en_v), 64'(exp_en));
    chk(busy === (q.size() > 0 || m_err), !rst_n ? "R10" : "R1", 64'(busy), 64'(q.size() > 0 || m_err));
    chk(err === m_err, !rst_n ? "R10" : "R9", 64'(err), 64'(m_err));
    chk(cg_valid === m_cg, !rst_n ? "R10" : "R5", 64'(cg_valid), 64'(m_cg));
    chk(reject === m_rej, !rst_n ? "R10" : "R8", 64'(reject), 64'(m_rej));
    chk(pt_valid === m_ptv, !rst_n ? "R10" : "R7", 64'(pt_valid), 64'(m_ptv));
    if (exp_en[1]) begin
      chk(pm_scalar === m_priv, m_mode ? "R6" : "R4", 64'(pm_scalar), 64'(m_priv));
      chk(pm_point === ((q[0] == 1) ? base_point : peer_pub), "R2", pm_point,
          (q[0] == 1) ? base_point : peer_pub);
    end
    if (exp_en[2]) chk(hash_in === m_sh, "R4", 64'(hash_in), 64'(m_sh));
    if (exp_en[3]) chk(mac_key === m_sh, "R4", 64'(mac_key), 64'(m_sh));
    if (exp_en[4]) begin
      chk(ciph_key === hf(m_sh), "R4", 64'(ciph_key), 64'(hf(m_sh)));
      chk(ciph_decrypt === m_mode, "R7", 64'(ciph_decrypt), 64'(m_mode));
    end
    if (m_cg) begin
      chk(text_out === cf(hf(m_sh), 1'b0), "R5", 64'(text_out), 64'(cf(hf(m_sh), 1'b0)));
      chk(pub_out === pmf(base_point, m_priv), "R5", pub_out, pmf(base_point, m_priv));
      chk(tag_out === mf(m_sh), "R5", 64'(tag_out), 64'(mf(m_sh)));
    end
    if (m_ptv) chk(text_out === cf(hf(m_sh), 1'b1), "R7", 64'(text_out), 64'(cf(hf(m_sh), 1'b1)));

    if (rst_n) begin
      m_cg = 0; m_rej = 0;
      if (m_err) begin
      end else if (q.size() == 0) begin
        if (start) begin
          m_mode = mode_rx; m_rxtag = rx_tag; m_ptv = 0;
          m_priv = mode_rx ? own_priv : SEED;
          m_sh = pmf(peer_pub, m_priv) >> 32;
          m_fire = 1; m_wait = 0;
          if (mode_rx) q = '{2, 3, 4, 5};
          else         q = '{0, 1, 2, 3, 4, 5};
        end
      end else if (m_fire) begin
        m_fire = 0; m_wait = 0;
      end else if (done_v[unit_of(q[0])]) begin
        if (q[0] == 4 && m_mode && mf(m_sh) != m_rxtag) begin
          q.delete(); m_rej = 1; m_ptv = 0;
        end else if (q[0] == 5) begin
          q.delete();
          if (m_mode) m_ptv = 1; else m_cg = 1;
        end else begin
          void'(q.pop_front()); m_fire = 1;
        end
      end else if (m_wait == TO - 1) begin
        m_err = 1;
      end else begin
        m_wait++;
      end
    end
  end

  task automatic do_reset();
    @(posedge clk); #1 rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic set_lat(int a, int b, int c, int d, int e);
    lat[0] = a; lat[1] = b; lat[2] = c; lat[3] = d; lat[4] = e;
  endtask

  task automatic go(bit md, bit noise);
    @(posedge clk); #1 start = 1; mode_rx = md;
    @(posedge clk); #1 start = 0;
    for (int k = 0; k < 6; k++) begin
      if (noise) begin
        start   = (k == 1 || k == 4);
        mode_rx = (k == 1 || k == 4) ? ~md : md;
        inj     = (k == 2) ? 5'b11000 : 5'b00000;
      end
      @(posedge clk); #1;
    end
    start = 0; inj = 0; mode_rx = md;
    @(negedge clk);
    while (busy && !err) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    set_lat(1, 1, 1, 1, 1);
    #1 rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (2) @(posedge clk);
    // R2 R4 R5: basic send
    go(0, 0);
    // R1 R3: varied latencies, starts and stray dones while busy
    set_lat(3, 5, 2, 4, 6);
    go(0, 1);
    // R3: done raised together with every enable is ignored
    set_lat(3, 3, 3, 3, 3);
    echo = 1; go(0, 0); echo = 0;
    // R6 R7: receive with matching tag
    set_lat(2, 4, 3, 2, 5);
    rx_tag = mf(pmf(peer_pub, own_priv) >> 32);
    go(1, 1);
    // R7: next accepted start clears pt_valid
    go(0, 0);
    // R8: mismatching tag
    rx_tag = rx_tag ^ 32'h1;
    go(1, 0);
    // R7: match again with unit latencies, other peer point
    peer_pub = 64'h0F0F_1234_A5A5_9876;
    rx_tag = mf(pmf(peer_pub, own_priv) >> 32);
    set_lat(1, 1, 1, 1, 1);
    go(1, 0);
    // R9 boundary: done in the last allowed cycle
    set_lat(TO, TO, TO, TO, TO);
    go(0, 0);
    // R9: one cycle too late on the hash
    set_lat(1, 1, TO + 1, 1, 1);
    go(0, 0);
    // R1 R9: start in error state is ignored
    @(posedge clk); #1 start = 1; mode_rx = 1;
    @(posedge clk); #1 start = 0;
    repeat (4) @(posedge clk);
    // R10: reset leaves the error state
    do_reset();
    set_lat(2, 2, 2, 2, 2);
    go(0, 0);
    repeat (3) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule